// File: doc/BRIEF.md
# Opcode-Decoded Integer Execute Unit

This block is the execute stage for a 32-bit instruction word that carries a 5-bit opcode in its low bits and operands in fixed fields whose layout depends on the opcode. When `valid_i` is high, the unit decodes the word and pulls out the operands. It then computes one of several results: an 8-bit add or subtract, a bitwise logic function, an inversion, a square, a short division, an unsigned compare, or a rotate of 1 to 5 places. The answer is packed into the result field that belongs to that opcode. All other bits of the result word stay zero.

The result word and three flags are registered. They appear one clock after the accepted instruction, together with a one-cycle `valid_o` pulse. The flags are arithmetic overflow, division by zero, and opcode not handled by this unit. Bit 31 of the instruction is a read/write marker (0 = read, 1 = write) that other stages use. It is copied into bit 31 of the result. Opcodes that belong to other units give a zero result with the not-handled flag set.

Top module: `op_exec_unit`

## Requirements
- R1: The opcode is `instr_i[4:0]`. One clock after a cycle with `valid_i` high, `valid_o` is high for exactly one cycle and `result_o[31]` equals that instruction's bit 31.
- R2: Opcode 0 (add) and opcode 1 (subtract, A minus B) use A = `instr_i[12:5]` and B = `instr_i[20:13]`. They write the result modulo 256 into `result_o[28:21]`.
- R3: Opcodes 4 AND, 5 OR, 6 NAND, 7 NOR, 8 XOR and 9 XNOR write the bitwise function of A and B into `result_o[28:21]`.
- R4: Opcode 10 writes the inverse of A, and opcode 11 writes the inverse of B, into `result_o[28:21]`.
- R5: Opcode 2 writes A*A into `result_o[27:13]`. If the square exceeds 32767, the field is 0x7FFF and `overflow_o` is high.
- R6: Opcode 3 divides A by the 5-bit divisor `instr_i[25:21]` and writes the quotient into `result_o[28:26]`. A quotient above 7 gives 7 with `overflow_o` high.
- R7: For opcode 3 with a zero divisor, the quotient field is 7, `div_zero_o` is high and `overflow_o` is low.
- R8: Opcodes 16 (A == B), 17 (A > B) and 18 (A < B) compare unsigned and write a single bit into `result_o[28]`.
- R9: Opcodes 19 to 23 rotate A by (opcode − 18) places and write the result into `result_o[28:21]`. `instr_i[14]` = 0 rotates left and 1 rotates right.
- R10: Opcodes 12 to 15 and 24 to 31 give `result_o[30:0]` = 0 and set `unhandled_o`.
- R11: Result bits outside the written field are zero. At most one flag is high, and a flag is high only in the cases named in R5, R6, R7 and R10.
- R12: After reset, `valid_o`, `result_o` and all flags are zero. While `valid_i` is low, the result and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| valid_i | input | 1 | Instruction valid strobe |
| result_o | output | 32 | Packed result word |
| valid_o | output | 1 | Result valid pulse |
| overflow_o | output | 1 | Square or quotient saturated |
| div_zero_o | output | 1 | Division by zero |
| unhandled_o | output | 1 | Opcode belongs to another unit |

## Verification
The assertions assume that `instr_i` is driven to known values whenever `valid_i` is high. They also assume that `valid_i` stays low during reset, so that the previous-cycle instruction they consult is the one that was captured. The bench changes `instr_i` and `valid_i` only on falling clock edges. It holds `valid_i` low through reset. It raises `valid_i` for one cycle per vector, so every registered result can be traced to exactly one accepted word.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OPND_W = 8;
  localparam int unsigned OPC_W  = 5;
  localparam int unsigned DIVR_W = 5;
  localparam int unsigned QUOT_W = 3;
  localparam int unsigned PROD_W = 15;
  localparam int unsigned ROT_MAX = 5;

  localparam logic [OPC_W-1:0] OP_ADD  = 5'd0;
  localparam logic [OPC_W-1:0] OP_SUB  = 5'd1;
  localparam logic [OPC_W-1:0] OP_SQR  = 5'd2;
  localparam logic [OPC_W-1:0] OP_DIV  = 5'd3;
  localparam logic [OPC_W-1:0] OP_AND  = 5'd4;
  localparam logic [OPC_W-1:0] OP_OR   = 5'd5;
  localparam logic [OPC_W-1:0] OP_NAND = 5'd6;
  localparam logic [OPC_W-1:0] OP_NOR  = 5'd7;
  localparam logic [OPC_W-1:0] OP_XOR  = 5'd8;
  localparam logic [OPC_W-1:0] OP_XNOR = 5'd9;
  localparam logic [OPC_W-1:0] OP_INVA = 5'd10;
  localparam logic [OPC_W-1:0] OP_INVB = 5'd11;
  localparam logic [OPC_W-1:0] OP_EQ   = 5'd16;
  localparam logic [OPC_W-1:0] OP_GT   = 5'd17;
  localparam logic [OPC_W-1:0] OP_LT   = 5'd18;
  localparam logic [OPC_W-1:0] OP_ROT1 = 5'd19;

  typedef struct packed {
    logic              rw;
    logic [OPC_W-1:0]  op;
    logic [OPND_W-1:0] a;
    logic [OPND_W-1:0] b;
    logic [DIVR_W-1:0] divr;
    logic              dir_r;
  } fields_t;

  typedef struct packed {
    logic [WORD_W-2:0] body;
    logic              ovf;
    logic              dz;
    logic              unh;
  } res_t;
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output fields_t           fld_o,
  output logic              is_arith_o,
  output logic              is_cmprot_o
);
  always_comb begin
    fld_o.rw    = instr_i[31];
    fld_o.op    = instr_i[4:0];
    fld_o.a     = instr_i[12:5];
    fld_o.b     = instr_i[20:13];
    fld_o.divr  = instr_i[25:21];
    fld_o.dir_r = instr_i[14];
  end

  assign is_arith_o  = (fld_o.op <= OP_INVB);
  assign is_cmprot_o = (fld_o.op >= OP_EQ) && (fld_o.op <= OP_ROT1 + 5'(ROT_MAX - 1));
endmodule

// File: rtl/opx_arith.sv
module opx_arith
  import opx_pkg::*;
(
  input  fields_t fld_i,
  output res_t    res_o
);
  localparam int unsigned SQ_W   = 2 * OPND_W;
  localparam int unsigned PROD_MAX = (1 << PROD_W) - 1;
  localparam int unsigned QUOT_MAX = (1 << QUOT_W) - 1;

  logic [SQ_W-1:0]   sq;
  logic [OPND_W-1:0] quo;
  logic [OPND_W-1:0] lo8;
  logic              lo_used;

  assign sq  = fld_i.a * fld_i.a;
  assign quo = (fld_i.divr == '0) ? '0 : fld_i.a / OPND_W'(fld_i.divr);

  always_comb begin
    lo_used = 1'b1;
    unique case (fld_i.op)
      OP_ADD:  lo8 = fld_i.a + fld_i.b;
      OP_SUB:  lo8 = fld_i.a - fld_i.b;
      OP_AND:  lo8 = fld_i.a & fld_i.b;
      OP_OR:   lo8 = fld_i.a | fld_i.b;
      OP_NAND: lo8 = ~(fld_i.a & fld_i.b);
      OP_NOR:  lo8 = ~(fld_i.a | fld_i.b);
      OP_XOR:  lo8 = fld_i.a ^ fld_i.b;
      OP_XNOR: lo8 = ~(fld_i.a ^ fld_i.b);
      OP_INVA: lo8 = ~fld_i.a;
      OP_INVB: lo8 = ~fld_i.b;
      default: begin lo8 = '0; lo_used = 1'b0; end
    endcase
  end

  always_comb begin
    res_o = '0;
    if (lo_used) begin
      res_o.body[28:21] = lo8;
    end else if (fld_i.op == OP_SQR) begin
      if (sq > SQ_W'(PROD_MAX)) begin
        res_o.body[27:13] = '1;
        res_o.ovf         = 1'b1;
      end else begin
        res_o.body[27:13] = sq[PROD_W-1:0];
      end
    end else if (fld_i.op == OP_DIV) begin
      if (fld_i.divr == '0) begin
        res_o.body[28:26] = '1;
        res_o.dz          = 1'b1;
      end else if (quo > OPND_W'(QUOT_MAX)) begin
        res_o.body[28:26] = '1;
        res_o.ovf         = 1'b1;
      end else begin
        res_o.body[28:26] = quo[QUOT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/opx_cmprot.sv
module opx_cmprot
  import opx_pkg::*;
(
  input  fields_t fld_i,
  output res_t    res_o
);
  logic [OPND_W-1:0] rot_l [ROT_MAX];
  logic [OPND_W-1:0] rot_r [ROT_MAX];

  for (genvar k = 1; k <= ROT_MAX; k++) begin : g_rot
    assign rot_l[k-1] = {fld_i.a[OPND_W-1-k:0], fld_i.a[OPND_W-1:OPND_W-k]};
    assign rot_r[k-1] = {fld_i.a[k-1:0], fld_i.a[OPND_W-1:k]};
  end

  logic [OPC_W-1:0] rot_idx;
  assign rot_idx = fld_i.op - OP_ROT1;

  always_comb begin
    res_o = '0;
    unique case (fld_i.op)
      OP_EQ: res_o.body[28] = (fld_i.a == fld_i.b);
      OP_GT: res_o.body[28] = (fld_i.a >  fld_i.b);
      OP_LT: res_o.body[28] = (fld_i.a <  fld_i.b);
      default: begin
        for (int i = 0; i < ROT_MAX; i++) begin
          if (rot_idx == OPC_W'(i))
            res_o.body[28:21] = fld_i.dir_r ? rot_r[i] : rot_l[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/op_exec_unit.sv
module op_exec_unit
  import opx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic        valid_i,
  output logic [31:0] result_o,
  output logic        valid_o,
  output logic        overflow_o,
  output logic        div_zero_o,
  output logic        unhandled_o
);
  fields_t fld;
  logic    is_arith, is_cmprot;
  res_t    res_ar, res_cr, res_d, res_q;
  logic    rw_q, valid_q;

  opx_decode u_dec (
    .instr_i     (instr_i),
    .fld_o       (fld),
    .is_arith_o  (is_arith),
    .is_cmprot_o (is_cmprot)
  );

  opx_arith u_ar (.fld_i(fld), .res_o(res_ar));
  opx_cmprot u_cr (.fld_i(fld), .res_o(res_cr));

  always_comb begin
    if (is_arith)       res_d = res_ar;
    else if (is_cmprot) res_d = res_cr;
    else begin
      res_d     = '0;
      res_d.unh = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      rw_q    <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        rw_q  <= fld.rw;
      end
    end
  end

  assign valid_o     = valid_q;
  assign result_o    = {rw_q, res_q.body};
  assign overflow_o  = res_q.ovf;
  assign div_zero_o  = res_q.dz;
  assign unhandled_o = res_q.unh;
endmodule

// File: rtl/opx_checker.sv
module opx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic        valid_i,
  input logic [31:0] result_o,
  input logic        valid_o,
  input logic        overflow_o,
  input logic        div_zero_o,
  input logic        unhandled_o
);
  p_valid_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  p_rw_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> result_o[31] == $past(instr_i[31]));

  p_sqr_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o && $past(instr_i[4:0]) == 5'd2) |-> result_o[27:13] == 15'h7fff);

  p_div_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && div_zero_o) |-> (result_o[28:26] == 3'b111 && !overflow_o));

  p_cmp_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(instr_i[4:0]) >= 5'd16 && $past(instr_i[4:0]) <= 5'd18)
      |-> (result_o[30:29] == 2'b00 && result_o[27:0] == 28'd0));

  p_unh_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && unhandled_o) |-> result_o[30:0] == 31'd0);

  p_flags_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({overflow_o, div_zero_o, unhandled_o}));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(result_o) && $stable(overflow_o) && $stable(unhandled_o)));
endmodule

bind op_exec_unit opx_checker chk_i (.*);

// File: tb/op_exec_unit_tb_top.sv
`timescale 1ns/1ps
module op_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic        valid_i = 1'b0;
  logic [31:0] result_o;
  logic        valid_o, overflow_o, div_zero_o, unhandled_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  op_exec_unit dut_i (.*);

  function automatic logic [31:0] mk(input logic rw, input logic [4:0] op,
                                     input logic [7:0] a, input logic [7:0] b);
    return {rw, 10'd0, b, a, op};
  endfunction
  function automatic logic [31:0] mkd(input logic rw, input logic [7:0] a, input logic [4:0] d);
    return {rw, 5'd0, d, 8'd0, a, 5'd3};
  endfunction
  function automatic logic [31:0] f8(input logic rw, input logic [7:0] v);
    return {rw, 2'b00, v, 21'd0};
  endfunction
  function automatic logic [31:0] f15(input logic rw, input logic [14:0] v);
    return {rw, 3'b000, v, 13'd0};
  endfunction
  function automatic logic [31:0] f3(input logic rw, input logic [2:0] v);
    return {rw, 2'b00, v, 26'd0};
  endfunction
  function automatic logic [31:0] f1(input logic rw, input logic v);
    return {rw, 2'b00, v, 28'd0};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] exp;
    logic [2:0]  fl;   // {unhandled, div_zero, overflow}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  // Full-word compares also cover R11 (unwritten bits zero, flags low)
  localparam vec_t VEC [NV] = '{
    '{mk(1'b1, 5'd0,  8'd200, 8'd100), f8(1'b1, 8'd44),  3'b000, 4'd2},  // R2
    '{mk(1'b0, 5'd1,  8'd5,   8'd10),  f8(1'b0, 8'd251), 3'b000, 4'd2},  // R2
    '{mk(1'b0, 5'd4,  8'hF0,  8'h3C),  f8(1'b0, 8'h30),  3'b000, 4'd3},  // R3
    '{mk(1'b1, 5'd5,  8'hF0,  8'h3C),  f8(1'b1, 8'hFC),  3'b000, 4'd3},
    '{mk(1'b0, 5'd6,  8'hF0,  8'h3C),  f8(1'b0, 8'hCF),  3'b000, 4'd3},
    '{mk(1'b0, 5'd7,  8'hF0,  8'h3C),  f8(1'b0, 8'h03),  3'b000, 4'd3},
    '{mk(1'b0, 5'd8,  8'hF0,  8'h3C),  f8(1'b0, 8'hCC),  3'b000, 4'd3},
    '{mk(1'b1, 5'd9,  8'hF0,  8'h3C),  f8(1'b1, 8'h33),  3'b000, 4'd3},
    '{mk(1'b0, 5'd10, 8'h5A,  8'hFF),  f8(1'b0, 8'hA5),  3'b000, 4'd4},  // R4
    '{mk(1'b0, 5'd11, 8'h5A,  8'h0F),  f8(1'b0, 8'hF0),  3'b000, 4'd4},
    '{mk(1'b0, 5'd2,  8'd181, 8'hFF),  f15(1'b0, 15'd32761), 3'b000, 4'd5}, // R5
    '{mk(1'b1, 5'd2,  8'd182, 8'h00),  f15(1'b1, 15'h7FFF),  3'b001, 4'd5},
    '{mkd(1'b0, 8'd50, 5'd7), f3(1'b0, 3'd7), 3'b000, 4'd6},            // R6
    '{mkd(1'b0, 8'd50, 5'd6), f3(1'b0, 3'd7), 3'b001, 4'd6},
    '{mkd(1'b1, 8'd13, 5'd4), f3(1'b1, 3'd3), 3'b000, 4'd6},
    '{mkd(1'b0, 8'd9,  5'd0), f3(1'b0, 3'd7), 3'b010, 4'd7},            // R7
    '{mk(1'b0, 5'd16, 8'd77,  8'd77),  f1(1'b0, 1'b1), 3'b000, 4'd8},    // R8
    '{mk(1'b0, 5'd17, 8'd10,  8'd200), f1(1'b0, 1'b0), 3'b000, 4'd8},
    '{mk(1'b1, 5'd18, 8'd10,  8'd200), f1(1'b1, 1'b1), 3'b000, 4'd8},
    '{mk(1'b0, 5'd19, 8'h81,  8'h00),  f8(1'b0, 8'h03), 3'b000, 4'd9},   // R9
    '{mk(1'b0, 5'd21, 8'h81,  8'h02),  f8(1'b0, 8'h30), 3'b000, 4'd9},
    '{mk(1'b0, 5'd23, 8'h01,  8'h00),  f8(1'b0, 8'h20), 3'b000, 4'd9},
    '{mk(1'b0, 5'd20, 8'h01,  8'h02),  f8(1'b0, 8'h40), 3'b000, 4'd9},
    '{mk(1'b0, 5'd22, 8'h12,  8'h00),  f8(1'b0, 8'h21), 3'b000, 4'd9},
    '{mk(1'b1, 5'd12, 8'hFF,  8'hFF),  32'h8000_0000,   3'b100, 4'd10},  // R10
    '{mk(1'b0, 5'd26, 8'hFF,  8'hFF),  32'h0,           3'b100, 4'd10},
    '{mk(1'b1, 5'd31, 8'h12,  8'h34),  32'h8000_0000,   3'b100, 4'd10}
  };

  task automatic check(input int req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] obs();
    return {valid_o, unhandled_o, div_zero_o, overflow_o, result_o};
  endfunction

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(12, obs(), 36'd0);  // R12 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      instr_i = VEC[i].ins;
      valid_i = 1'b1;
      @(negedge clk_i);
      valid_i = 1'b0;
      instr_i = 32'hFFFF_FFFF;
      check(int'(VEC[i].req), obs(), {1'b1, VEC[i].fl, VEC[i].exp});
      @(negedge clk_i);
      check(1, {35'd0, valid_o}, 36'd0);  // R1 single-cycle pulse
    end

    // R12: hold while valid_i low, despite a changing instruction
    instr_i = mk(1'b1, 5'd2, 8'd200, 8'd0);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      instr_i = mk(1'b0, 5'(k), 8'(k), 8'd3);
      @(negedge clk_i);
      check(12, obs(), {1'b0, 3'b001, f15(1'b1, 15'h7FFF)});
    end

    // R1: back-to-back valid words, rw bit tracked per word
    instr_i = mk(1'b1, 5'd0, 8'd1, 8'd2);
    valid_i = 1'b1;
    @(negedge clk_i);
    check(1, obs(), {1'b1, 3'b000, f8(1'b1, 8'd3)});
    instr_i = mk(1'b0, 5'd1, 8'd0, 8'd1);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(2, obs(), {1'b1, 3'b000, f8(1'b0, 8'd255)});  // R2 wrap

    // R12: reset mid-run clears state
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(12, obs(), 36'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule